// File: doc/BRIEF.md
# Program Exception Interrupt Filter

This block decides whether a reported program exception turns into a program interrupt. Each report is a 4-bit exception code (1 to 15) with a one-cycle valid strobe. The block compares it with the current 64-bit status word. Four exception kinds (fixed-point overflow, decimal overflow, exponent underflow and significance) can be switched off by status-word bits 36 to 39. Every other kind always interrupts.

When an interrupt is taken, the block writes the old status word to fixed low storage, with the interruption code inserted. It then reads the new status word from a second fixed address and presents it to the rest of the processor. A masked exception produces only a one-cycle suppressed pulse and no storage traffic. A supervisor-call request is never masked. It uses its own pair of old and new status-word addresses, and a parameter chooses whether it beats a program exception that arrives in the same cycle.

Status-word bit n is numbered from the most significant end, so bit n sits at port index 63-n.

Top module: `prog_irq_filter`

## Requirements
- R1: After reset, `mem_req`, `taken_o`, `suppressed_o`, `done_o` and `busy_o` are 0.
- R2: An accepted exception whose code is 1 to 15 but not 8, 10, 13 or 14 is always taken, whatever bits 36 to 39 hold: `taken_o` pulses in the cycle after acceptance.
- R3: Codes 8, 10, 13 and 14 (fixed-point overflow, decimal overflow, exponent underflow, significance) are gated by status-word bits 36, 37, 38 and 39 (port indices 27, 26, 25, 24). A one allows the interrupt; a zero suppresses it.
- R4: A suppressed exception raises `suppressed_o` for exactly one cycle, in the cycle after acceptance, and starts no memory request.
- R5: A taken program interrupt first writes (`mem_we`=1) to byte address `PGM_OLD_ADDR` (default 40). The write data is the current status word with bits 16 to 31 (port indices 47:32) replaced by the zero-extended code. It then reads (`mem_we`=0) from `PGM_NEW_ADDR` (default 104).
- R6: When the read completes, `new_sw_o` holds the read data and `done_o` pulses for one cycle in the cycle after the completing edge. `busy_o` is 0 from that cycle on.
- R7: A supervisor call is never masked. It writes to `SVC_OLD_ADDR` and reads from `SVC_NEW_ADDR`, with `svc_code` zero-extended into bits 16 to 31, and `svc_o` is 1 with its `taken_o` pulse.
- R8: When a supervisor call and an allowed program exception arrive together, the call is served if `SVC_FIRST`=1 and the exception if `SVC_FIRST`=0. The loser is dropped with no pulse. A suppressed exception that arrives with a call still pulses `suppressed_o`.
- R9: Each transfer completes on an edge with `mem_req` and `mem_ready` both high. While it waits, the address, data and direction hold steady, and each interrupt makes exactly two transfers.
- R10: Reports with code 0, and any report or call presented while `busy_o` is 1, are ignored: no pulse and no memory traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Program exception report strobe |
| exc_code | input | 4 | Exception code, 1 to 15 |
| svc_valid | input | 1 | Supervisor-call request strobe |
| svc_code | input | SVC_CODE_W | Supervisor-call number |
| cur_sw | input | 64 | Current status word |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write old word, 0 = read new word |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 64 | Old status word being stored |
| mem_rdata | input | 64 | Word returned by the read |
| mem_ready | input | 1 | Transfer completes on this edge |
| new_sw_o | output | 64 | Fetched new status word |
| taken_o | output | 1 | One-cycle pulse: interrupt taken |
| suppressed_o | output | 1 | One-cycle pulse: exception masked |
| svc_o | output | 1 | Current interrupt is a supervisor call |
| done_o | output | 1 | One-cycle pulse: new status word ready |
| busy_o | output | 1 | Interrupt sequence in progress |

## Verification
The bench sweeps all fifteen codes against all sixteen mask patterns. A wrong mapping from mask bit to code, or an inverted mask sense, would therefore show up as a taken interrupt where a suppression was due, or the reverse. Memory-ready stalls are inserted so that a sequencer that advances without the handshake, or lets the address or data drift, stores the wrong word or makes extra transfers. Simultaneous call-and-exception cases, code 0 and requests during a busy sequence target a design that serves the wrong winner, that reports a dropped request, or that restarts in the middle of a sequence.

// File: rtl/pif_pkg.sv
package pif_pkg;
  localparam int SW_W   = 64;
  localparam int CODE_W = 4;
  localparam int IC_W   = 16;
  localparam int IC_LO  = SW_W - 1 - 31;  // status-word bit 31 -> port index 32

  typedef enum logic [1:0] {ST_IDLE, ST_STORE, ST_FETCH} pif_state_e;

  // Status-word bits are numbered from the most significant end.
  function automatic int sw_idx(input int b);
    return SW_W - 1 - b;
  endfunction

  function automatic logic is_maskable(input logic [CODE_W-1:0] c);
    return (c == 4'd8) || (c == 4'd10) || (c == 4'd13) || (c == 4'd14);
  endfunction

  // 1 when the status word lets this code interrupt.
  function automatic logic mask_allows(input logic [CODE_W-1:0] c,
                                       input logic [SW_W-1:0] sw);
    case (c)
      4'd8:    return sw[sw_idx(36)];
      4'd10:   return sw[sw_idx(37)];
      4'd13:   return sw[sw_idx(38)];
      4'd14:   return sw[sw_idx(39)];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [SW_W-1:0] insert_icode(input logic [SW_W-1:0] sw,
                                                   input logic [IC_W-1:0] ic);
    logic [SW_W-1:0] r;
    r = sw;
    r[IC_LO +: IC_W] = ic;
    return r;
  endfunction
endpackage

// File: rtl/pif_classify.sv
module pif_classify
  import pif_pkg::*;
#(
  parameter int SVC_CODE_W = 8,
  parameter bit SVC_FIRST  = 1'b0
) (
  input  logic                  exc_valid,
  input  logic [CODE_W-1:0]     exc_code,
  input  logic                  svc_valid,
  input  logic [SVC_CODE_W-1:0] svc_code,
  input  logic [SW_W-1:0]       cur_sw,
  output logic                  pick_take,
  output logic                  pick_svc,
  output logic                  pick_supp,
  output logic [SW_W-1:0]       pick_word
);
  logic exc_live, exc_allow, exc_take, svc_take;
  logic [IC_W-1:0] icode;

  always_comb begin
    exc_live  = exc_valid && (exc_code != '0);
    exc_allow = mask_allows(exc_code, cur_sw);
    exc_take  = exc_live && exc_allow;
    svc_take  = svc_valid && (SVC_FIRST || !exc_take);
    pick_svc  = svc_take;
    pick_take = svc_take || exc_take;
    pick_supp = exc_live && !exc_allow;
    icode     = svc_take ? IC_W'(svc_code) : IC_W'(exc_code);
    pick_word = insert_icode(cur_sw, icode);
  end
endmodule

// File: rtl/pif_seq.sv
module pif_seq
  import pif_pkg::*;
#(
  parameter int              ADDR_W       = 24,
  parameter logic [ADDR_W-1:0] PGM_OLD_ADDR = ADDR_W'(40),
  parameter logic [ADDR_W-1:0] PGM_NEW_ADDR = ADDR_W'(104),
  parameter logic [ADDR_W-1:0] SVC_OLD_ADDR = ADDR_W'(32),
  parameter logic [ADDR_W-1:0] SVC_NEW_ADDR = ADDR_W'(96)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_take,
  input  logic              go_svc,
  input  logic              go_supp,
  input  logic [SW_W-1:0]   go_word,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [SW_W-1:0]   mem_wdata,
  input  logic [SW_W-1:0]   mem_rdata,
  input  logic              mem_ready,
  output logic [SW_W-1:0]   new_sw_o,
  output logic              taken_o,
  output logic              suppressed_o,
  output logic              svc_o,
  output logic              done_o,
  output logic              busy_o
);
  pif_state_e      state;
  logic [SW_W-1:0] old_q;
  logic            idle, store_fire, fetch_fire;

  assign idle       = (state == ST_IDLE);
  assign store_fire = (state == ST_STORE) && mem_ready;
  assign fetch_fire = (state == ST_FETCH) && mem_ready;
  assign busy_o     = !idle;
  assign mem_req    = !idle;
  assign mem_we     = (state == ST_STORE);
  assign mem_wdata  = old_q;

  always_comb begin
    case (state)
      ST_STORE: mem_addr = svc_o ? SVC_OLD_ADDR : PGM_OLD_ADDR;
      ST_FETCH: mem_addr = svc_o ? SVC_NEW_ADDR : PGM_NEW_ADDR;
      default:  mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      old_q        <= '0;
      new_sw_o     <= '0;
      taken_o      <= 1'b0;
      suppressed_o <= 1'b0;
      svc_o        <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      taken_o      <= 1'b0;
      suppressed_o <= 1'b0;
      done_o       <= 1'b0;
      case (state)
        ST_IDLE: begin
          suppressed_o <= go_supp;
          if (go_take) begin
            taken_o <= 1'b1;
            svc_o   <= go_svc;
            old_q   <= go_word;
            state   <= ST_STORE;
          end
        end
        ST_STORE: if (store_fire) state <= ST_FETCH;
        ST_FETCH: if (fetch_fire) begin
          new_sw_o <= mem_rdata;
          done_o   <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: a stalled transfer keeps its address, data and direction
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we));
  // R4: a lone suppression starts no traffic
  p_supp_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    suppressed_o && !taken_o |-> !mem_req);
  // R5: a taken interrupt opens with the store
  p_store_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> mem_req && mem_we);
  // R5: the read follows the completed write
  p_read_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ready |=> mem_req && !mem_we);
  // R6: done only after a completed read
  p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(fetch_fire) && !busy_o);
endmodule

// File: rtl/prog_irq_filter.sv
module prog_irq_filter
  import pif_pkg::*;
#(
  parameter int                ADDR_W       = 24,
  parameter int                SVC_CODE_W   = 8,
  parameter logic [ADDR_W-1:0] PGM_OLD_ADDR = ADDR_W'(40),
  parameter logic [ADDR_W-1:0] PGM_NEW_ADDR = ADDR_W'(104),
  parameter logic [ADDR_W-1:0] SVC_OLD_ADDR = ADDR_W'(32),
  parameter logic [ADDR_W-1:0] SVC_NEW_ADDR = ADDR_W'(96),
  parameter bit                SVC_FIRST    = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  exc_valid,
  input  logic [3:0]            exc_code,
  input  logic                  svc_valid,
  input  logic [SVC_CODE_W-1:0] svc_code,
  input  logic [63:0]           cur_sw,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [63:0]           mem_wdata,
  input  logic [63:0]           mem_rdata,
  input  logic                  mem_ready,
  output logic [63:0]           new_sw_o,
  output logic                  taken_o,
  output logic                  suppressed_o,
  output logic                  svc_o,
  output logic                  done_o,
  output logic                  busy_o
);
  logic            pick_take, pick_svc, pick_supp;
  logic [SW_W-1:0] pick_word;

  pif_classify #(.SVC_CODE_W(SVC_CODE_W), .SVC_FIRST(SVC_FIRST)) u_classify (
    .exc_valid (exc_valid),
    .exc_code  (exc_code),
    .svc_valid (svc_valid),
    .svc_code  (svc_code),
    .cur_sw    (cur_sw),
    .pick_take (pick_take),
    .pick_svc  (pick_svc),
    .pick_supp (pick_supp),
    .pick_word (pick_word)
  );

  pif_seq #(
    .ADDR_W(ADDR_W), .PGM_OLD_ADDR(PGM_OLD_ADDR), .PGM_NEW_ADDR(PGM_NEW_ADDR),
    .SVC_OLD_ADDR(SVC_OLD_ADDR), .SVC_NEW_ADDR(SVC_NEW_ADDR)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_take      (pick_take),
    .go_svc       (pick_svc),
    .go_supp      (pick_supp),
    .go_word      (pick_word),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata),
    .mem_ready    (mem_ready),
    .new_sw_o     (new_sw_o),
    .taken_o      (taken_o),
    .suppressed_o (suppressed_o),
    .svc_o        (svc_o),
    .done_o       (done_o),
    .busy_o       (busy_o)
  );

  // R2: unmaskable codes always interrupt when accepted
  p_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && (exc_code != 4'd0) && !is_maskable(exc_code) && !busy_o |=> taken_o);
  // R3: a cleared mask bit suppresses its code
  p_maskzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && is_maskable(exc_code) && !mask_allows(exc_code, cur_sw) && !busy_o |=> suppressed_o);
  // R7: supervisor calls are never masked
  p_svc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid && !busy_o |=> taken_o);
  // R10: nothing starts while a sequence runs
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !taken_o && !suppressed_o);
endmodule

// File: tb/test_prog_irq_filter.sv
module test_prog_irq_filter;
  localparam bit SVC_FIRST_TB = 1'b1;
  localparam int AW = 24;

  typedef struct {
    bit          supp;
    bit          svc;
    logic [23:0] old_addr;
    logic [63:0] old_word;
    logic [23:0] new_addr;
    logic [63:0] new_word;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic exc_valid = 0, svc_valid = 0, mem_ready = 0;
  logic [3:0] exc_code = 0;
  logic [7:0] svc_code = 0;
  logic [63:0] cur_sw = 0, mem_rdata = 0;
  logic mem_req, mem_we, taken_o, suppressed_o, svc_o, done_o, busy_o;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata, new_sw_o;

  int checks = 0, fails = 0, nseq = 0, xfers = 0;
  bit finished = 0;
  exp_t q[$];
  exp_t cur;

  always #2 clk = ~clk;

  prog_irq_filter #(.ADDR_W(AW), .SVC_FIRST(SVC_FIRST_TB)) i_prog_irq_filter (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .svc_valid(svc_valid), .svc_code(svc_code), .cur_sw(cur_sw),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .new_sw_o(new_sw_o),
    .taken_o(taken_o), .suppressed_o(suppressed_o), .svc_o(svc_o),
    .done_o(done_o), .busy_o(busy_o));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit ref_allow(input logic [3:0] c, input logic [3:0] m);
    if (c == 4'd8)  return m[3];
    if (c == 4'd10) return m[2];
    if (c == 4'd13) return m[1];
    if (c == 4'd14) return m[0];
    return 1'b1;
  endfunction

  // Driver: computes the expected outcome, pushes it, then drives one report.
  task automatic issue(input bit ev, input logic [3:0] code, input bit sv,
                       input logic [7:0] sc, input logic [3:0] m);
    logic [63:0] sw;
    bit live, allow, etake, stake;
    exp_t e;
    nseq++;
    sw = {32'hA5C3_0F00 ^ nseq, 32'h1357_9BDF + nseq};
    sw[63-36] = m[3]; sw[63-37] = m[2]; sw[63-38] = m[1]; sw[63-39] = m[0];
    live  = ev && (code != 0);
    allow = ref_allow(code, m);
    etake = live && allow;
    stake = sv && (SVC_FIRST_TB || !etake);
    if (live && !allow) begin
      e = '{supp: 1'b1, svc: 1'b0, old_addr: '0, old_word: '0, new_addr: '0, new_word: '0};
      q.push_back(e);
    end
    if (stake || etake) begin
      e.supp     = 1'b0;
      e.svc      = stake;
      e.old_addr = stake ? 24'd32 : 24'd40;
      e.new_addr = stake ? 24'd96 : 24'd104;
      e.old_word = {sw[63:48], stake ? {8'h00, sc} : {12'h000, code}, sw[31:0]};
      e.new_word = {32'h5EED_0000 + nseq, ~sw[31:0]};
      q.push_back(e);
    end
    @(negedge clk);
    exc_valid = ev; exc_code = code; svc_valid = sv; svc_code = sc; cur_sw = sw;
    @(negedge clk);
    exc_valid = 0; svc_valid = 0;
    while (busy_o) @(negedge clk);
  endtask

  task automatic expect_quiet(input string req);
    repeat (3) begin
      @(negedge clk);
      check(!taken_o && !suppressed_o && !mem_req, req,
            {61'd0, taken_o, suppressed_o, mem_req}, 64'd0);
    end
  endtask

  // Memory-ready pattern with stalls
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    mem_ready = (cyc % 4) != 1;
  end

  // Monitor: pops expected items and compares against the outputs
  always @(negedge clk) begin
    if (rst_n) begin
      if (suppressed_o) begin
        if (q.size() == 0) check(0, "R10 unexpected suppress", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(e.supp, "R3 suppress vs take", 1, {63'd0, e.supp});
          if (!taken_o) check(!mem_req, "R4 no traffic on suppress", {63'd0, mem_req}, 0);
        end
      end
      if (taken_o) begin
        if (q.size() == 0) check(0, "R10 unexpected take", 1, 0);
        else begin
          cur = q.pop_front();
          check(!cur.supp, "R2 take vs suppress", 1, {63'd0, !cur.supp});
          check(svc_o == cur.svc, "R8 winner kind", {63'd0, svc_o}, {63'd0, cur.svc});
          mem_rdata = cur.new_word;
          xfers = 0;
        end
      end
      if (mem_req && mem_ready) begin
        xfers++;
        if (mem_we) begin
          check(mem_addr == cur.old_addr, cur.svc ? "R7 old addr" : "R5 old addr",
                {40'd0, mem_addr}, {40'd0, cur.old_addr});
          check(mem_wdata == cur.old_word, cur.svc ? "R7 old word" : "R5 old word",
                mem_wdata, cur.old_word);
        end else begin
          check(mem_addr == cur.new_addr, "R5 new addr", {40'd0, mem_addr}, {40'd0, cur.new_addr});
        end
      end
      if (done_o) begin
        check(new_sw_o == cur.new_word, "R6 new status word", new_sw_o, cur.new_word);
        check(xfers == 2, "R9 transfer count", xfers, 2);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!mem_req && !taken_o && !suppressed_o && !done_o && !busy_o, "R1 reset state",
          {59'd0, mem_req, taken_o, suppressed_o, done_o, busy_o}, 0);
    rst_n = 1;
    // R2 R3: every code under every mask value
    for (int m = 0; m < 16; m++)
      for (int c = 1; c < 16; c++)
        issue(1'b1, 4'(c), 1'b0, 8'h00, 4'(m));
    // R7: supervisor call alone, mask fully cleared
    issue(1'b0, 4'd0, 1'b1, 8'h3C, 4'h0);
    // R8: call with an allowed exception, and with a masked one
    issue(1'b1, 4'd6, 1'b1, 8'h11, 4'hF);
    issue(1'b1, 4'd8, 1'b1, 8'h22, 4'h0);
    // R10: code 0 is ignored
    @(negedge clk); exc_valid = 1; exc_code = 0;
    @(negedge clk); exc_valid = 0;
    expect_quiet("R10 code zero");
    // R10: requests during a busy sequence are ignored
    begin
      exp_t e;
      logic [63:0] sw;
      nseq++;
      sw = 64'h0123_4567_89AB_CDEF;
      e = '{supp: 1'b0, svc: 1'b0, old_addr: 24'd40, old_word: {sw[63:48], 16'h0005, sw[31:0]},
            new_addr: 24'd104, new_word: 64'hFEED_F00D_0000_0001};
      q.push_back(e);
      @(negedge clk); exc_valid = 1; exc_code = 5; cur_sw = sw;
      @(negedge clk); exc_valid = 1; exc_code = 2; svc_valid = 1;
      @(negedge clk); exc_valid = 0; svc_valid = 0;
      while (busy_o) @(negedge clk);
      expect_quiet("R10 busy ignore");
    end
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R10 scoreboard drained", q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end
endmodule